// File: doc/BRIEF.md
# Fixed Memory Window Request Router

This block sits behind one fixed host memory window. Each incoming read or write carries an offset relative to the start of that window. The router adds the configured window base to form an absolute host address. From that address it selects one of up to sixteen downstream host bridges by interleaving. It then forwards the request, still carrying the absolute address, to a single downstream port tagged with the chosen bridge index.

The interleave set may hold any number of targets from 1 to 16, so the index is a true remainder and not a bit slice. A bit-serial remainder unit computes it. The router stays busy while that unit runs, and it holds only one request at a time.

The downstream side answers with a response that may carry a "no device behind this target" flag. On such a miss the router builds the reply itself:
- A read that misses returns zero data with the error bit set.
- A write that misses is discarded and completes without error.

A combinational configuration check raises a flag when the window settings are unusable.

The controller has six states:
- `ST_IDLE`: ready for a request. On `req_valid` it goes to `ST_START`.
- `ST_START`: launches the remainder unit, then always goes to `ST_CALC`.
- `ST_CALC`: waits for the remainder. On done it goes to `ST_ISSUE`.
- `ST_ISSUE`: offers the request downstream. On `dn_ready` it goes to `ST_WAIT`. If `dn_rsp_valid` arrives in that same cycle, it goes straight to `ST_RESP` instead.
- `ST_WAIT`: waits for the downstream answer. On `dn_rsp_valid` it goes to `ST_RESP`.
- `ST_RESP`: presents the reply upstream. On `rsp_ready` it goes back to `ST_IDLE`.

Top module: `fmw_router`

## Requirements
- R1: The downstream address `dn_addr` equals `cfg_base + req_addr`, where the offset is zero-extended to the host address width. The same absolute address is forwarded for reads and writes.
- R2: `dn_tgt` equals (host address >> (8 + granularity code)) modulo `cfg_ntgt`. This holds for every target count from 1 to 16, including counts that are not powers of two, and `dn_tgt` is always below `cfg_ntgt`.
- R3: When `cfg_gran_set` is 0, the granularity code in use is 0, meaning 256-byte interleave, whatever `cfg_gran_enc` holds.
- R4: `cfg_bad` is 1 exactly when any of the following holds:
  - bits [27:0] of `cfg_size` are nonzero, so the size is not a multiple of 256 MiB;
  - `cfg_ntgt` is 0 or above 16;
  - `cfg_gran_set` is 1 and `cfg_gran_enc` is above 6.
- R5: A read whose downstream response has `dn_rsp_nodev`=1 completes with `rsp_err`=1 and `rsp_rdata`=0.
- R6: A write whose downstream response has `dn_rsp_nodev`=1 completes with `rsp_err`=0 and `rsp_rdata`=0.
- R7: When `dn_rsp_nodev`=0, `rsp_err` and `rsp_rdata` equal `dn_rsp_err` and `dn_rsp_rdata`.
- R8: `dn_write`, `dn_size` and `dn_wdata` equal the accepted request's `req_write`, `req_size` and `req_wdata`. Any size from 1 to 8 bytes and any byte alignment is accepted.
- R9: Only one request is in flight. `req_ready` is 1 only in the idle state, drops in the cycle after an acceptance, and returns the cycle after the response handshake.
- R10: `dn_valid` with its fields stays stable until `dn_ready`. `rsp_valid` with its fields stays stable until `rsp_ready`.
- R11: After reset, `req_ready`=1, `dn_valid`=0 and `rsp_valid`=0.
- R12: A downstream response that arrives in the same cycle as `dn_ready` is captured. The reply then follows without waiting in `ST_WAIT`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_base | input | HPA_W | Window base host address |
| cfg_size | input | HPA_W | Window size in bytes |
| cfg_ntgt | input | CNT_W | Number of interleave targets |
| cfg_gran_set | input | 1 | Granularity code supplied |
| cfg_gran_enc | input | 3 | Granularity code (256 << code bytes) |
| cfg_bad | output | 1 | Configuration invalid |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | OFF_W | Offset inside the window |
| req_size | input | 4 | Access size in bytes, 1 to 8 |
| req_wdata | input | DATA_W | Little-endian write data |
| dn_valid | output | 1 | Downstream request valid |
| dn_ready | input | 1 | Downstream request taken |
| dn_write | output | 1 | Downstream direction |
| dn_addr | output | HPA_W | Absolute host address |
| dn_size | output | 4 | Access size |
| dn_wdata | output | DATA_W | Write data |
| dn_tgt | output | TGT_W | Selected host-bridge index |
| dn_rsp_valid | input | 1 | Downstream response valid |
| dn_rsp_nodev | input | 1 | Target has no device |
| dn_rsp_err | input | 1 | Device error |
| dn_rsp_rdata | input | DATA_W | Device read data |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response taken |
| rsp_err | output | 1 | Error / poison indication |
| rsp_rdata | output | DATA_W | Read data |

## Verification
Two events can meet in one cycle: the downstream acceptance of a request and the arrival of its response. The bench drives `dn_ready` and `dn_rsp_valid` together for every even target count, and separates them by a cycle for every odd count. In both cases the reply must carry exactly the data, the error bit and the miss handling expected for that request, and no response may be lost. The sweep covers all target counts 1 to 16, four granularity codes and several unaligned offsets. The expected index is computed arithmetically and compared with `dn_tgt`.

// File: rtl/fmw_pkg.sv
package fmw_pkg;
    localparam int GRAN_BASE_SHIFT = 8;   // code 0 => 256-byte stride
    localparam int WIN_ALIGN_BITS  = 28;  // 256 MiB window quantum
    localparam int MAX_GRAN_CODE   = 6;
    localparam int GRAN_CODE_W     = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_CALC,
        ST_ISSUE,
        ST_WAIT,
        ST_RESP
    } rtr_state_t;
endpackage

// File: rtl/fmw_cfg_check.sv
module fmw_cfg_check
    import fmw_pkg::*;
#(
    parameter int HPA_W   = 40,
    parameter int CNT_W   = 5,
    parameter int MAX_TGT = 16
) (
    input  logic [HPA_W-1:0]       size,
    input  logic [CNT_W-1:0]       ntgt,
    input  logic                   gran_set,
    input  logic [GRAN_CODE_W-1:0] gran_code,
    output logic [GRAN_CODE_W-1:0] eff_code,
    output logic                   bad
);
    logic size_bad, cnt_bad, gran_bad;

    always_comb begin
        size_bad = |size[WIN_ALIGN_BITS-1:0];
        cnt_bad  = (ntgt == '0) || (ntgt > CNT_W'(MAX_TGT));
        gran_bad = gran_set && (gran_code > GRAN_CODE_W'(MAX_GRAN_CODE));
        bad      = size_bad || cnt_bad || gran_bad;
        eff_code = gran_set ? gran_code : '0;
    end
endmodule

// File: rtl/fmw_mod_serial.sv
module fmw_mod_serial #(
    parameter int DIV_W = 32,
    parameter int RW    = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [DIV_W-1:0] dividend,
    input  logic [RW-1:0]    divisor,
    output logic             done,
    output logic [RW-1:0]    rem
);
    localparam int STEP_W = $clog2(DIV_W + 1);

    logic [DIV_W-1:0]  sh_q;
    logic [RW-1:0]     rem_q;
    logic [STEP_W-1:0] step_q;
    logic              busy_q;
    logic              done_q;
    logic [RW-1:0]     dv;
    logic [RW:0]       trial;
    logic [RW-1:0]     next_rem;

    always_comb begin
        dv       = (divisor == '0) ? RW'(1) : divisor;
        trial    = {rem_q, sh_q[DIV_W-1]};
        next_rem = (trial >= {1'b0, dv}) ? RW'(trial - {1'b0, dv}) : RW'(trial);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q   <= '0;
            rem_q  <= '0;
            step_q <= '0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else if (start) begin
            sh_q   <= dividend;
            rem_q  <= '0;
            step_q <= '0;
            busy_q <= 1'b1;
            done_q <= 1'b0;
        end else if (busy_q) begin
            sh_q   <= sh_q << 1;
            rem_q  <= next_rem;
            step_q <= step_q + 1'b1;
            if (step_q == STEP_W'(DIV_W - 1)) begin
                busy_q <= 1'b0;
                done_q <= 1'b1;
            end
        end else begin
            done_q <= 1'b0;
        end
    end

    assign done = done_q;
    assign rem  = rem_q;
endmodule

// File: rtl/fmw_router.sv
module fmw_router
    import fmw_pkg::*;
#(
    parameter int OFF_W   = 32,
    parameter int HPA_W   = 40,
    parameter int DATA_W  = 64,
    parameter int MAX_TGT = 16,
    localparam int TGT_W   = $clog2(MAX_TGT),
    localparam int CNT_W   = $clog2(MAX_TGT + 1),
    localparam int CHUNK_W = HPA_W - GRAN_BASE_SHIFT
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [HPA_W-1:0]       cfg_base,
    input  logic [HPA_W-1:0]       cfg_size,
    input  logic [CNT_W-1:0]       cfg_ntgt,
    input  logic                   cfg_gran_set,
    input  logic [GRAN_CODE_W-1:0] cfg_gran_enc,
    output logic                   cfg_bad,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic                   req_write,
    input  logic [OFF_W-1:0]       req_addr,
    input  logic [3:0]             req_size,
    input  logic [DATA_W-1:0]      req_wdata,
    output logic                   dn_valid,
    input  logic                   dn_ready,
    output logic                   dn_write,
    output logic [HPA_W-1:0]       dn_addr,
    output logic [3:0]             dn_size,
    output logic [DATA_W-1:0]      dn_wdata,
    output logic [TGT_W-1:0]       dn_tgt,
    input  logic                   dn_rsp_valid,
    input  logic                   dn_rsp_nodev,
    input  logic                   dn_rsp_err,
    input  logic [DATA_W-1:0]      dn_rsp_rdata,
    output logic                   rsp_valid,
    input  logic                   rsp_ready,
    output logic                   rsp_err,
    output logic [DATA_W-1:0]      rsp_rdata
);
    rtr_state_t state_q, state_d;

    logic [HPA_W-1:0]       hpa_q;
    logic                   wr_q;
    logic [3:0]             size_q;
    logic [DATA_W-1:0]      wdata_q;
    logic [TGT_W-1:0]       tgt_q;
    logic                   err_q;
    logic [DATA_W-1:0]      rdata_q;
    logic [GRAN_CODE_W-1:0] eff_code;
    logic [3:0]             shamt;
    logic [CHUNK_W-1:0]     chunk;
    logic                   mod_start;
    logic                   mod_done;
    logic [CNT_W-1:0]       mod_rem;
    logic                   accept;
    logic                   rsp_capture;

    fmw_cfg_check #(
        .HPA_W  (HPA_W),
        .CNT_W  (CNT_W),
        .MAX_TGT(MAX_TGT)
    ) u_cfg (
        .size     (cfg_size),
        .ntgt     (cfg_ntgt),
        .gran_set (cfg_gran_set),
        .gran_code(cfg_gran_enc),
        .eff_code (eff_code),
        .bad      (cfg_bad)
    );

    always_comb begin
        shamt = 4'(GRAN_BASE_SHIFT) + 4'(eff_code);
        chunk = CHUNK_W'(hpa_q >> shamt);
    end

    fmw_mod_serial #(
        .DIV_W(CHUNK_W),
        .RW   (CNT_W)
    ) u_mod (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (mod_start),
        .dividend(chunk),
        .divisor (cfg_ntgt),
        .done    (mod_done),
        .rem     (mod_rem)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_valid) state_d = ST_START;
            ST_START: state_d = ST_CALC;
            ST_CALC:  if (mod_done) state_d = ST_ISSUE;
            ST_ISSUE: if (dn_ready) state_d = dn_rsp_valid ? ST_RESP : ST_WAIT;
            ST_WAIT:  if (dn_rsp_valid) state_d = ST_RESP;
            ST_RESP:  if (rsp_ready) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Outputs and strobes
    always_comb begin
        req_ready   = 1'b0;
        dn_valid    = 1'b0;
        rsp_valid   = 1'b0;
        mod_start   = 1'b0;
        rsp_capture = 1'b0;
        unique case (state_q)
            ST_IDLE:  req_ready = 1'b1;
            ST_START: mod_start = 1'b1;
            ST_CALC:  ;
            ST_ISSUE: begin
                dn_valid    = 1'b1;
                rsp_capture = dn_ready && dn_rsp_valid;
            end
            ST_WAIT:  rsp_capture = dn_rsp_valid;
            ST_RESP:  rsp_valid = 1'b1;
            default:  ;
        endcase
        accept = req_ready && req_valid;
    end

    // Request, index and response holding registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hpa_q   <= '0;
            wr_q    <= 1'b0;
            size_q  <= '0;
            wdata_q <= '0;
            tgt_q   <= '0;
            err_q   <= 1'b0;
            rdata_q <= '0;
        end else begin
            if (accept) begin
                hpa_q   <= cfg_base + HPA_W'(req_addr);
                wr_q    <= req_write;
                size_q  <= req_size;
                wdata_q <= req_wdata;
            end
            if (state_q == ST_CALC && mod_done) begin
                tgt_q <= TGT_W'(mod_rem);
            end
            if (rsp_capture) begin
                if (dn_rsp_nodev) begin
                    err_q   <= !wr_q;
                    rdata_q <= '0;
                end else begin
                    err_q   <= dn_rsp_err;
                    rdata_q <= dn_rsp_rdata;
                end
            end
        end
    end

    assign dn_write  = wr_q;
    assign dn_addr   = hpa_q;
    assign dn_size   = size_q;
    assign dn_wdata  = wdata_q;
    assign dn_tgt    = tgt_q;
    assign rsp_err   = err_q;
    assign rsp_rdata = rdata_q;
endmodule

// File: rtl/fmw_router_chk.sv
module fmw_router_chk #(
    parameter int HPA_W   = 40,
    parameter int DATA_W  = 64,
    parameter int MAX_TGT = 16,
    parameter int TGT_W   = 4,
    parameter int CNT_W   = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              dn_valid,
    input logic              dn_ready,
    input logic              dn_write,
    input logic [HPA_W-1:0]  dn_addr,
    input logic [3:0]        dn_size,
    input logic [TGT_W-1:0]  dn_tgt,
    input logic              rsp_valid,
    input logic              rsp_ready,
    input logic              rsp_err,
    input logic [DATA_W-1:0] rsp_rdata,
    input logic [CNT_W-1:0]  cfg_ntgt
);
    p_one_flight_r9: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !req_ready);

    p_idle_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !dn_valid && !rsp_valid);

    p_dn_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        dn_valid && !dn_ready |=> dn_valid && $stable(dn_addr) && $stable(dn_tgt)
                                   && $stable(dn_write) && $stable(dn_size));

    p_rsp_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_err) && $stable(rsp_rdata));

    p_tgt_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        dn_valid && cfg_ntgt != '0 && cfg_ntgt <= CNT_W'(MAX_TGT)
            |-> CNT_W'(dn_tgt) < cfg_ntgt);
endmodule

bind fmw_router fmw_router_chk #(
    .HPA_W  (HPA_W),
    .DATA_W (DATA_W),
    .MAX_TGT(MAX_TGT),
    .TGT_W  (TGT_W),
    .CNT_W  (CNT_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_ready(req_ready),
    .dn_valid (dn_valid),
    .dn_ready (dn_ready),
    .dn_write (dn_write),
    .dn_addr  (dn_addr),
    .dn_size  (dn_size),
    .dn_tgt   (dn_tgt),
    .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready),
    .rsp_err  (rsp_err),
    .rsp_rdata(rsp_rdata),
    .cfg_ntgt (cfg_ntgt)
);

// File: tb/sim_fmw_router.sv
`timescale 1ns/1ps
module sim_fmw_router;
    localparam int OFF_W = 32, HPA_W = 40, DATA_W = 64, MAX_TGT = 16;
    localparam int TGT_W = 4, CNT_W = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;  // 50 MHz

    logic [HPA_W-1:0]  cfg_base = 40'h12_3000_0000;
    logic [HPA_W-1:0]  cfg_size = 40'h00_3000_0000;
    logic [CNT_W-1:0]  cfg_ntgt = 5'd1;
    logic              cfg_gran_set = 1'b0;
    logic [2:0]        cfg_gran_enc = 3'd0;
    logic              cfg_bad;
    logic              req_valid = 1'b0, req_ready, req_write = 1'b0;
    logic [OFF_W-1:0]  req_addr = '0;
    logic [3:0]        req_size = 4'd1;
    logic [DATA_W-1:0] req_wdata = '0;
    logic              dn_valid, dn_ready = 1'b0, dn_write;
    logic [HPA_W-1:0]  dn_addr;
    logic [3:0]        dn_size;
    logic [DATA_W-1:0] dn_wdata;
    logic [TGT_W-1:0]  dn_tgt;
    logic              dn_rsp_valid = 1'b0, dn_rsp_nodev = 1'b0, dn_rsp_err = 1'b0;
    logic [DATA_W-1:0] dn_rsp_rdata = '0;
    logic              rsp_valid, rsp_ready = 1'b0, rsp_err;
    logic [DATA_W-1:0] rsp_rdata;

    fmw_router u0 (.*);

    int total = 0;
    int fails = 0;
    bit finished = 0;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] dev_data(input logic [HPA_W-1:0] a);
        return {24'h0, a} ^ 64'hC3C3_0000_5A5A_F00F;
    endfunction

    // One full transaction with bench-side downstream model
    task automatic txn(input bit wr, input logic [OFF_W-1:0] off, input logic [3:0] sz,
                       input logic [63:0] wd, input bit nodev, input bit deverr,
                       input bit same_cycle, input int gcode);
        longint unsigned hpa;
        longint unsigned exp_tgt;
        logic [63:0] exp_data;
        bit exp_err;
        int t;
        hpa = longint'(cfg_base) + longint'(off);
        exp_tgt = (hpa >> (8 + gcode)) % longint'(cfg_ntgt);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = off; req_size = sz; req_wdata = wd;
        chk("R9 ready in idle", 64'(req_ready), 64'd1);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R9 busy after accept", 64'(req_ready), 64'd0);
        t = 0;
        while (!dn_valid && t < 200) begin @(negedge clk); t++; end
        chk("R2 dn_valid reached", 64'(dn_valid), 64'd1);
        chk("R1 host address", 64'(dn_addr), hpa);
        chk("R2 target index", 64'(dn_tgt), exp_tgt);
        chk("R8 write flag", 64'(dn_write), 64'(wr));
        chk("R8 size", 64'(dn_size), 64'(sz));
        chk("R8 write data", dn_wdata, wd);
        // Stall one cycle before taking the request
        @(negedge clk);
        chk("R10 dn held", 64'(dn_valid), 64'd1);
        dn_ready = 1'b1;
        dn_rsp_nodev = nodev; dn_rsp_err = deverr; dn_rsp_rdata = dev_data(dn_addr);
        if (same_cycle) begin
            dn_rsp_valid = 1'b1;  // R12 response with acceptance
            @(negedge clk);
            dn_ready = 1'b0; dn_rsp_valid = 1'b0;
            chk("R12 reply right after", 64'(rsp_valid), 64'd1);
        end else begin
            @(negedge clk);
            dn_ready = 1'b0;
            chk("R12 no reply before response", 64'(rsp_valid), 64'd0);
            @(negedge clk);
            dn_rsp_valid = 1'b1;
            @(negedge clk);
            dn_rsp_valid = 1'b0;
        end
        t = 0;
        while (!rsp_valid && t < 50) begin @(negedge clk); t++; end
        if (nodev) begin
            exp_err = !wr; exp_data = '0;
        end else begin
            exp_err = deverr; exp_data = dev_data(40'(hpa));
        end
        if (nodev && !wr) begin
            chk("R5 read miss err", 64'(rsp_err), 64'd1);
            chk("R5 read miss data", rsp_rdata, 64'd0);
        end else if (nodev) begin
            chk("R6 write miss err", 64'(rsp_err), 64'd0);
            chk("R6 write miss data", rsp_rdata, 64'd0);
        end else begin
            chk("R7 device err", 64'(rsp_err), 64'(exp_err));
            chk("R7 device data", rsp_rdata, exp_data);
        end
        @(negedge clk);
        chk("R10 rsp held", 64'(rsp_valid), 64'd1);
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
        chk("R9 ready after reply", 64'(req_ready), 64'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R11 reset req_ready", 64'(req_ready), 64'd1);
        chk("R11 reset dn_valid", 64'(dn_valid), 64'd0);
        chk("R11 reset rsp_valid", 64'(rsp_valid), 64'd0);
        rst_n = 1'b1;

        // R4 configuration validity
        @(negedge clk);
        cfg_size = 40'h00_3000_0000; cfg_ntgt = 5'd3; cfg_gran_set = 1'b1; cfg_gran_enc = 3'd6;
        #1 chk("R4 good cfg", 64'(cfg_bad), 64'd0);
        cfg_size = 40'h00_3000_1000;
        #1 chk("R4 size not 256MiB multiple", 64'(cfg_bad), 64'd1);
        cfg_size = 40'h00_1000_0000; cfg_ntgt = 5'd0;
        #1 chk("R4 zero targets", 64'(cfg_bad), 64'd1);
        cfg_ntgt = 5'd17;
        #1 chk("R4 too many targets", 64'(cfg_bad), 64'd1);
        cfg_ntgt = 5'd16; cfg_gran_enc = 3'd7;
        #1 chk("R4 granularity code 7", 64'(cfg_bad), 64'd1);
        cfg_gran_set = 1'b0;
        #1 chk("R4 unset code ignored", 64'(cfg_bad), 64'd0);

        // R3: unset granularity means 256-byte stride
        cfg_ntgt = 5'd5; cfg_gran_set = 1'b0; cfg_gran_enc = 3'd3;
        txn(1'b0, 32'h0000_0A37, 4'd4, 64'h0, 1'b0, 1'b0, 1'b0, 0);  // R3
        txn(1'b0, 32'h0001_2F01, 4'd8, 64'h0, 1'b0, 1'b1, 1'b1, 0);  // R3

        // Sweep of target counts, granularity codes and offsets
        for (int n = 1; n <= 16; n++) begin
            for (int e = 0; e < 4; e++) begin
                cfg_ntgt = CNT_W'(n); cfg_gran_set = 1'b1; cfg_gran_enc = 3'(e);
                for (int o = 0; o < 3; o++) begin
                    txn(1'((n + e + o) % 2),
                        32'(o * 32'h0034_5671 + n * 32'h0000_0D00 + e * 7 + 1),
                        4'((n + o) % 8 + 1),
                        64'h0123_4567_89AB_CDEF ^ 64'(n * 131 + e),
                        (o == 2), 1'((e + o) % 3 == 1), ((n % 2) == 0), e);
                end
            end
        end
        finished = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end
endmodule